// File: doc/BRIEF.md
# Interrupt Vector Resolver

This block takes the encoded status word of an interrupt controller together with a 16-bit vector of pending DMA tasks. From them it produces a single 8-bit interrupt number. The number has two parts. The upper two bits carry a group code. The lower six bits carry the index of the source inside that group.

Three request fields are examined in a fixed order: critical first, then main, then peripheral. Two escape codes redirect the decode to the peripheral field. A critical index of 2 stands for a high-priority peripheral, and a main index of 4 stands for a low-priority peripheral. A peripheral index of 0 stands for the shared DMA source. In that case the source is resolved to the lowest pending task in the task vector. A hit flag tells whether any interrupt was found.

The block is used as a one-deep stream stage. A request is accepted when `in_valid` and `in_ready` are both high at a clock edge. The result appears on the next cycle with `out_valid` high, and stays there until the consumer takes it with `out_ready`. Back-pressure follows one rule: `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A request offered while `in_ready` is low is not taken and has no effect on the output.

Top module: `ivr_top`

## Requirements
- R1: The interrupt number is formed as group code times 64 plus a 6-bit index. The group code sits in bits 7:6 and uses 0 for critical, 1 for main, 2 for peripheral and 3 for DMA task.
- R2: When status bit 10 is set and the 2-bit critical index in bits 9:8 is not 2, the result is group 0 with that index. This holds regardless of the other fields.
- R3: When bit 10 is clear and status bit 21 is set, and the 5-bit main index in bits 20:16 is not 4, the result is group 1 with that index.
- R4: When bits 10 and 21 are both clear and status bit 29 is set, the 5-bit peripheral index in bits 28:24 is decoded. A non-zero index gives group 2 with that index.
- R5: A critical index of 2 sends the decode to the peripheral field in bits 28:24, whether or not bit 29 is set.
- R6: A main index of 4, with bit 10 clear, sends the decode to the peripheral field in bits 28:24, whether or not bit 29 is set.
- R7: A peripheral index of 0 gives group 3. Its index is the bit position of the lowest set bit of `task_pend`.
- R8: A peripheral index of 0 with `task_pend` all zero gives `irq_hit` low and `irq_num` 0.
- R9: When none of bits 10, 21 and 29 is set, the result is `irq_hit` low and `irq_num` 0.
- R10: A request accepted at one clock edge is presented with `out_valid` high after that edge. While `out_ready` is low, `out_valid`, `irq_num` and `irq_hit` hold their values.
- R11: After reset, `out_valid` is low, `irq_num` is 0 and `irq_hit` is low.
- R12: `in_ready` is high when `out_valid` is low or `out_ready` is high, and low otherwise. A request offered while `in_ready` is low leaves the held output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The stage can take a request |
| enc_status | input | 32 | Encoded status word |
| task_pend | input | 16 | Pending DMA task vector |
| out_valid | output | 1 | A result is held (done) |
| out_ready | input | 1 | The consumer takes the result |
| irq_num | output | 8 | Resolved interrupt number |
| irq_hit | output | 1 | An interrupt was found |

## Verification
Every result is due one clock after the edge at which its request is accepted, and there is no other latency in the block. The bench drives inputs on the falling edge and checks `out_valid`, `irq_num` and `irq_hit` at the next falling edge, which is half a cycle after the result has been registered. During a stall the bench checks at every falling edge that the held result has not changed and that `in_ready` is low. A stalled second request is then checked to appear one cycle after `out_ready` rises.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int STATUS_W  = 32;
  localparam int NUM_W     = 8;
  localparam int IDX_W     = 6;
  localparam int GRP_W     = NUM_W - IDX_W;

  // field layout of the encoded status word
  localparam int CRIT_FLAG = 10;
  localparam int CRIT_LSB  = 8;
  localparam int CRIT_W    = 2;
  localparam int MAIN_FLAG = 21;
  localparam int MAIN_LSB  = 16;
  localparam int MAIN_W    = 5;
  localparam int PER_FLAG  = 29;
  localparam int PER_LSB   = 24;
  localparam int PER_W     = 5;

  // escape codes that redirect to the peripheral field
  localparam logic [CRIT_W-1:0] CRIT_ESC_PER = 2'd2;
  localparam logic [MAIN_W-1:0] MAIN_ESC_PER = 5'd4;
  localparam logic [PER_W-1:0]  PER_ESC_DMA  = 5'd0;

  localparam logic [STATUS_W-1:0] USED_MASK =
      (STATUS_W'(1) << CRIT_FLAG) | (STATUS_W'((1 << CRIT_W) - 1) << CRIT_LSB) |
      (STATUS_W'(1) << MAIN_FLAG) | (STATUS_W'((1 << MAIN_W) - 1) << MAIN_LSB) |
      (STATUS_W'(1) << PER_FLAG)  | (STATUS_W'((1 << PER_W) - 1) << PER_LSB);

  typedef enum logic [GRP_W-1:0] {
    GRP_CRIT = 2'd0,
    GRP_MAIN = 2'd1,
    GRP_PER  = 2'd2,
    GRP_DMA  = 2'd3
  } grp_e;

  typedef struct packed {
    logic             hit;
    grp_e             grp;
    logic [IDX_W-1:0] idx;
  } result_t;
endpackage

// File: rtl/ivr_lowest_set.sv
module ivr_lowest_set #(
  parameter int W   = 16,
  parameter int P_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]   vec,
  output logic           found,
  output logic [P_W-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = P_W'(i);
      end
    end
  end
endmodule

// File: rtl/ivr_field_decode.sv
module ivr_field_decode
  import ivr_pkg::*;
#(
  parameter int TASK_IDX_W = 4
) (
  input  logic [STATUS_W-1:0]   status,
  input  logic                  task_found,
  input  logic [TASK_IDX_W-1:0] task_pos,
  output result_t               res
);
  logic              crit_flag, main_flag, per_flag;
  logic [CRIT_W-1:0] crit_idx;
  logic [MAIN_W-1:0] main_idx;
  logic [PER_W-1:0]  per_idx;
  logic              go_per;
  result_t           per_res;
  logic              unused_status;

  assign crit_flag = status[CRIT_FLAG];
  assign main_flag = status[MAIN_FLAG];
  assign per_flag  = status[PER_FLAG];
  assign crit_idx  = status[CRIT_LSB +: CRIT_W];
  assign main_idx  = status[MAIN_LSB +: MAIN_W];
  assign per_idx   = status[PER_LSB +: PER_W];
  assign unused_status = ^(status & ~USED_MASK);

  // peripheral sub-decoder, including the DMA task expansion
  always_comb begin
    per_res = '0;
    if (per_idx == PER_ESC_DMA) begin
      if (task_found) begin
        per_res.hit = 1'b1;
        per_res.grp = GRP_DMA;
        per_res.idx[TASK_IDX_W-1:0] = task_pos;
      end
    end else begin
      per_res.hit = 1'b1;
      per_res.grp = GRP_PER;
      per_res.idx = IDX_W'(per_idx);
    end
  end

  // strict priority across the three fields
  always_comb begin
    res    = '0;
    go_per = 1'b0;
    if (crit_flag) begin
      if (crit_idx == CRIT_ESC_PER) begin
        go_per = 1'b1;
      end else begin
        res.hit = 1'b1;
        res.grp = GRP_CRIT;
        res.idx = IDX_W'(crit_idx);
      end
    end else if (main_flag) begin
      if (main_idx == MAIN_ESC_PER) begin
        go_per = 1'b1;
      end else begin
        res.hit = 1'b1;
        res.grp = GRP_MAIN;
        res.idx = IDX_W'(main_idx);
      end
    end else if (per_flag) begin
      go_per = 1'b1;
    end
    if (go_per) res = per_res;
  end
endmodule

// File: rtl/ivr_out_stage.sv
module ivr_out_stage #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ivr_top.sv
module ivr_top
  import ivr_pkg::*;
#(
  parameter int TASKS      = 16,
  parameter int TASK_IDX_W = $clog2(TASKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [31:0]         enc_status,
  input  logic [TASKS-1:0]    task_pend,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NUM_W-1:0]    irq_num,
  output logic                irq_hit
);
  localparam int RES_W = $bits(result_t);

  logic                  task_found;
  logic [TASK_IDX_W-1:0] task_pos;
  result_t               dec_res;
  result_t               held_res;

  ivr_lowest_set #(.W(TASKS), .P_W(TASK_IDX_W)) u_lowest (
    .vec   (task_pend),
    .found (task_found),
    .pos   (task_pos)
  );

  ivr_field_decode #(.TASK_IDX_W(TASK_IDX_W)) u_decode (
    .status     (enc_status),
    .task_found (task_found),
    .task_pos   (task_pos),
    .res        (dec_res)
  );

  ivr_out_stage #(.W(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (dec_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held_res)
  );

  assign irq_hit = held_res.hit;
  assign irq_num = {held_res.grp, held_res.idx};
endmodule

// File: rtl/ivr_checker.sv
module ivr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] enc_status,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  irq_num,
  input logic        irq_hit
);
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(irq_num) && $stable(irq_hit)); // R10
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R12
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R12
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !irq_hit |-> irq_num == 8'd0); // R8
  AST_CRIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && irq_hit && irq_num[7:6] == 2'd0 |-> irq_num[5:2] == 4'd0 && irq_num[1:0] != 2'd2); // R2
  AST_MAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && irq_hit && irq_num[7:6] == 2'd1 |-> !irq_num[5] && irq_num[4:0] != 5'd4); // R6
  AST_DMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && irq_hit && irq_num[7:6] == 2'd3 |-> irq_num[5:4] == 2'd0); // R7
  AST_NO_FLAG_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) && $past(!enc_status[10] && !enc_status[21] && !enc_status[29])
    |-> out_valid && !irq_hit); // R9
endmodule

bind ivr_top ivr_checker u_ivr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .enc_status (enc_status),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .irq_num    (irq_num),
  .irq_hit    (irq_hit)
);

// File: tb/test_ivr_top.sv
`timescale 1ns/1ps
module test_ivr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] enc_status = '0;
  logic [15:0] task_pend = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  irq_num;
  logic        irq_hit;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ivr_top i_ivr_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .enc_status(enc_status), .task_pend(task_pend), .out_valid(out_valid),
    .out_ready(out_ready), .irq_num(irq_num), .irq_hit(irq_hit)
  );

  // expected {hit, number} built from the requirements
  function automatic logic [8:0] model(input logic [31:0] s, input logic [15:0] t);
    logic to_per;
    logic [4:0] p;
    to_per = 1'b0;
    if (s[10]) begin
      if (s[9:8] == 2'd2) to_per = 1'b1;                   // R5
      else return {1'b1, 2'd0, 4'd0, s[9:8]};              // R2
    end else if (s[21]) begin
      if (s[20:16] == 5'd4) to_per = 1'b1;                 // R6
      else return {1'b1, 2'd1, 1'b0, s[20:16]};            // R3
    end else if (s[29]) to_per = 1'b1;                     // R4
    else return 9'd0;                                      // R9
    p = s[28:24];
    if (p != 5'd0) return {1'b1, 2'd2, 1'b0, p};           // R1 R4
    for (int i = 0; i < 16; i++)
      if (t[i]) return {1'b1, 2'd3, 2'b00, 4'(i)};         // R7
    return 9'd0;                                           // R8
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_res(input string req, input logic [8:0] e);
    check(out_valid === 1'b1, {req, " out_valid"}, 32'(out_valid), 32'd1);
    check({irq_hit, irq_num} === e, req, 32'({irq_hit, irq_num}), 32'(e));
  endtask

  // one request with no back-pressure; result due one edge later
  task automatic send(input logic [31:0] s, input logic [15:0] t, input string req);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; enc_status = s; task_pend = t;
    check(in_ready === 1'b1, "R12 ready when draining", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check_res(req, model(s, t));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11 out_valid", 32'(out_valid), 32'd0);
    check(irq_num === 8'd0, "R11 irq_num", 32'(irq_num), 32'd0);
    check(irq_hit === 1'b0, "R11 irq_hit", 32'(irq_hit), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R11 idle after reset", 32'(out_valid), 32'd0);
    check(in_ready === 1'b1, "R12 ready when empty", 32'(in_ready), 32'd1);

    send(32'h0000_0000, 16'hFFFF, "R9 no flags");
    send(32'h0000_0400, 16'h0000, "R2 crit 0");
    send(32'h0000_0700, 16'h0000, "R2 crit 3");
    send(32'h2F3F_0500, 16'h0000, "R2 crit wins over main");
    send(32'h0700_0600, 16'h0000, "R5 crit escape no per flag");
    send(32'h2000_0600, 16'h0500, "R5 crit escape to DMA");
    send(32'h0029_0000, 16'h0000, "R3 main 9");
    send(32'h3F3F_0000, 16'h0000, "R3 main 31");
    send(32'h0524_0000, 16'h0000, "R6 main escape");
    send(32'h2024_0000, 16'h0000, "R8 DMA empty via main escape");
    send(32'h3F00_0000, 16'h0000, "R4 per 31");
    send(32'h2000_0000, 16'h8000, "R7 DMA task 15");
    send(32'h2000_0000, 16'hFFFF, "R7 DMA task 0");
    send(32'h2000_0000, 16'h0000, "R8 DMA empty");
    send(32'h1F1F_0300, 16'h0000, "R9 flags clear, fields set");

    // back-pressure: first result held, second request waits
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; enc_status = 32'h0000_0500; task_pend = 16'h0;
    @(negedge clk);
    check_res("R10 stall first", model(32'h0000_0500, 16'h0));
    enc_status = 32'h2000_0000; task_pend = 16'h0040;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(in_ready === 1'b0, "R12 not ready in stall", 32'(in_ready), 32'd0);
      check_res("R12 held through stall", model(32'h0000_0500, 16'h0));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_res("R10 queued after stall", model(32'h2000_0000, 16'h0040));
    @(negedge clk);
    check(out_valid === 1'b0, "R10 drained", 32'(out_valid), 32'd0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] s;
      logic [15:0] t;
      s = $urandom;
      t = 16'($urandom);
      if ($urandom_range(0, 3) == 0) s[10] = 1'b0;
      if ($urandom_range(0, 2) == 0) s[21] = 1'b0;
      if ($urandom_range(0, 4) == 0) s[9:8] = 2'd2;
      if ($urandom_range(0, 4) == 0) s[20:16] = 5'd4;
      if ($urandom_range(0, 3) == 0) s[28:24] = 5'd0;
      if ($urandom_range(0, 3) == 0) t = 16'(1) << $urandom_range(0, 15);
      if ($urandom_range(0, 7) == 0) t = 16'h0;
      send(s, t, "R1 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule